// File: doc/BRIEF.md
# DRAM Status-Register Read Sequencer

This block is a small command sequencer that sits inside a low-power DDR SDRAM controller and fetches the device's status word. When the controller raises a request, the sequencer first closes every bank with an all-bank precharge and waits out the precharge time. It then arms the status read with a load-mode-register command that carries a reserved bank code, keeps the command bus idle for a programmable gap, and issues a READ.

The device answers with a two-beat burst. The burst length does not depend on the burst setting in the mode register. The first beat arrives one CAS latency after the READ and holds the status word. The sequencer latches that beat and drops the second one. It then keeps the command bus idle for a recovery interval and pulses done, after which the controller may issue its next command.

The timing values (precharge time, arm-to-read gap, recovery interval and CAS latency) are run-time inputs. They are captured when a request is accepted, so the controller may change them while a sequence is running without disturbing it.

Top module: `srr_sequencer`

## Requirements
- R1: During and directly after a synchronous active-low reset, the command bus carries NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111), done is low and the status output is zero.
- R2: A request seen in the idle state produces a precharge (0010) in the next cycle, with address bit 10 high so that all banks are closed.
- R3: The load-mode-register command (0000) follows the precharge after exactly max(tRP,1) cycles. It drives bank bits `ba[1:0]` = 01 (bit 0 set, bit 1 clear) and an all-zero address.
- R4: The READ (0101) follows the load-mode-register command after exactly max(tSRR,1) cycles, and only NOP is driven between the two.
- R5: The effective CAS latency is 3 when `cas_lat_i` is 3 and 2 for any other value. The data bus is sampled exactly that many cycles after the READ, and the status output updates only if the valid strobe is high in that cycle. With the strobe low, the previous status is kept.
- R6: The second beat of the burst, and any data-bus activity outside the sampling cycle, leaves the status output unchanged.
- R7: Done is high for exactly one cycle, max(tSRC, CL+1) cycles after the READ. Only NOP is driven in between, and the status output already holds the new word in that cycle.
- R8: A request raised while a sequence is in progress is ignored, and no further precharge appears after done unless a new request arrives.
- R9: The timing inputs are captured when a request is accepted. Changing them during a sequence does not alter that sequence's gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start a status read (sampled in idle only) |
| t_rp_i | input | TMR_W | Precharge wait in cycles |
| t_srr_i | input | TMR_W | Arm-to-READ gap in cycles |
| t_src_i | input | TMR_W | READ-to-next-command recovery in cycles |
| cas_lat_i | input | 2 | CAS latency setting (3, else treated as 2) |
| cmd_o | output | 4 | `{cs_n,ras_n,cas_n,we_n}` command |
| ba_o | output | BANK_W | Bank select, bit 0 first |
| addr_o | output | ADDR_W | Address bus |
| dq_i | input | DATA_W | Read data from the device |
| dq_valid_i | input | 1 | Read data valid strobe |
| status_o | output | DATA_W | Last captured status word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches every cycle. It checks the encoding of each command and the fields each command carries (all-bank flag on precharge, reserved bank code and zero address on the arming command). It checks that commands come in the order precharge, arm, READ, done. It also checks that the status output changes only after a READ and that done lasts a single cycle. The exact cycle gaps depend on timing values captured at request time, and only the bench scenarios can show them. The same holds for selecting the first beat over the second, for keeping the old status when the strobe is missing, and for ignoring requests and mid-sequence timing changes while busy. For these the bench sweeps every combination of small timing values and both latencies.

// File: rtl/srr_pkg.sv
// Package srr_pkg
// Shared command encodings, sequencer states and the reserved bank code
// used to arm a status read. Assumes {cs_n,ras_n,cas_n,we_n} ordering.
package srr_pkg;

    typedef enum logic [3:0] {
        CMD_LMR  = 4'b0000,
        CMD_PRE  = 4'b0010,
        CMD_READ = 4'b0101,
        CMD_NOP  = 4'b0111
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_TRP,
        ST_LMR,
        ST_TSRR,
        ST_READ,
        ST_TSRC
    } seq_state_e;

    // Bank code that turns the load-mode command into a status-read arm
    localparam logic [1:0] ARM_BANK = 2'b01;

    // Address bit that selects all banks on a precharge
    localparam int AP_BIT = 10;

endpackage

// File: rtl/srr_wait_timer.sv
// Module srr_wait_timer
// Shared down-counter for the sequencer's waits. A load sets the count;
// the count then falls by one per cycle and stops at zero. last_o marks
// the cycle in which the count equals one, i.e. the final wait cycle.
// Assumes load and counting never overlap for two different waits.
module srr_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down towards zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    // Final wait cycle indicator
    always_comb last_o = (cnt_q == W'(1));

endmodule

// File: rtl/srr_capture.sv
// Module srr_capture
// Latches the first beat of the status burst. arm_i is high in the READ
// cycle; the data bus is sampled exactly cl_i cycles later, if the valid
// strobe is high. Any later beat is ignored until the next arm.
// Assumes cl_i is 2 or 3.
module srr_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [1:0]        cl_i,
    input  logic [DATA_W-1:0] dq_i,
    input  logic              dq_valid_i,
    output logic [DATA_W-1:0] status_o
);

    logic [1:0] lat_q;
    logic       armed_q;

    // Latency countdown and single-beat capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q    <= '0;
            armed_q  <= 1'b0;
            status_o <= '0;
        end else if (arm_i) begin
            lat_q   <= cl_i - 2'd1;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            if (lat_q == 2'd0) begin
                armed_q <= 1'b0;
                if (dq_valid_i) begin
                    status_o <= dq_i;
                end
            end else begin
                lat_q <= lat_q - 2'd1;
            end
        end
    end

endmodule

// File: rtl/srr_cmd_encoder.sv
// Module srr_cmd_encoder
// Maps the sequencer state to the command, bank and address buses.
// Purely combinational; the state register makes the outputs clean.
// Assumes ADDR_W is wide enough to hold the all-bank bit.
module srr_cmd_encoder
    import srr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input  seq_state_e        state_i,
    output logic [3:0]        cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    // Command, bank and address per state
    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        unique case (state_i)
            ST_PRE: begin
                cmd_o          = CMD_PRE;
                addr_o[AP_BIT] = 1'b1;
            end
            ST_LMR: begin
                cmd_o = CMD_LMR;
                ba_o  = BANK_W'(ARM_BANK);
            end
            ST_READ: cmd_o = CMD_READ;
            default: cmd_o = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/srr_sequencer.sv
// Module srr_sequencer (top)
// Status-register read sequencer: precharge all, wait tRP, arm with a
// load-mode command on the reserved bank code, wait tSRR, READ, capture
// the first beat CL cycles later, hold the bus idle for the recovery time
// and pulse done. Timing inputs are captured when a request is accepted.
// Assumes TMR_W >= 3 and ADDR_W > 10.
module srr_sequencer
    import srr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int TMR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [TMR_W-1:0]  t_rp_i,
    input  logic [TMR_W-1:0]  t_srr_i,
    input  logic [TMR_W-1:0]  t_src_i,
    input  logic [1:0]        cas_lat_i,
    output logic [3:0]        cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o,
    input  logic [DATA_W-1:0] dq_i,
    input  logic              dq_valid_i,
    output logic [DATA_W-1:0] status_o,
    output logic              done_o
);

    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    seq_state_e       state_q, state_d;
    logic [TMR_W-1:0] trp_q, tsrr_q, tsrc_q;
    logic [1:0]       cl_q;
    logic [TMR_W-1:0] trp_ld, tsrr_ld, src_min, src_len, src_ld;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_load, tmr_last;
    logic             accept;

    // A request is taken only from idle
    always_comb accept = (state_q == ST_IDLE) && req_i;

    // Snapshot of the timing inputs at accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trp_q  <= '0;
            tsrr_q <= '0;
            tsrc_q <= '0;
            cl_q   <= 2'd2;
        end else if (accept) begin
            trp_q  <= t_rp_i;
            tsrr_q <= t_srr_i;
            tsrc_q <= t_src_i;
            cl_q   <= (cas_lat_i == 2'd3) ? 2'd3 : 2'd2;
        end
    end

    // Timer load values: each wait is max(t,1) cycles command to command
    always_comb begin
        trp_ld  = (trp_q  == '0) ? '0 : trp_q  - ONE;
        tsrr_ld = (tsrr_q == '0) ? '0 : tsrr_q - ONE;
        src_min = TMR_W'(cl_q) + ONE;
        src_len = (tsrc_q > src_min) ? tsrc_q : src_min;
        src_ld  = src_len - ONE;
    end

    // Next-state and timer-load selection
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_PRE;
            ST_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = trp_ld;
                state_d  = (trp_ld == '0) ? ST_LMR : ST_TRP;
            end
            ST_TRP:  if (tmr_last) state_d = ST_LMR;
            ST_LMR: begin
                tmr_load = 1'b1;
                tmr_val  = tsrr_ld;
                state_d  = (tsrr_ld == '0) ? ST_READ : ST_TSRR;
            end
            ST_TSRR: if (tmr_last) state_d = ST_READ;
            ST_READ: begin
                tmr_load = 1'b1;
                tmr_val  = src_ld;
                state_d  = ST_TSRC;
            end
            ST_TSRC: if (tmr_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Done pulse on the return to idle
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (state_q == ST_TSRC) && tmr_last;
    end

    srr_wait_timer #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .last_o     (tmr_last)
    );

    srr_capture #(.DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (state_q == ST_READ),
        .cl_i       (cl_q),
        .dq_i       (dq_i),
        .dq_valid_i (dq_valid_i),
        .status_o   (status_o)
    );

    srr_cmd_encoder #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_enc (
        .state_i (state_q),
        .cmd_o   (cmd_o),
        .ba_o    (ba_o),
        .addr_o  (addr_o)
    );

endmodule

// File: rtl/srr_sequencer_chk.sv
// Module srr_sequencer_chk
// Cycle-by-cycle protocol checker for srr_sequencer, attached by bind.
// Tracks the last non-NOP command to check command order and fields.
module srr_sequencer_chk
    import srr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cmd_o,
    input logic [BANK_W-1:0] ba_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] status_o,
    input logic              done_o
);

    logic [3:0] last_cmd_q;

    // Remember the most recent non-NOP command
    always_ff @(posedge clk) begin
        if (!rst_n)                last_cmd_q <= CMD_NOP;
        else if (cmd_o != CMD_NOP) last_cmd_q <= cmd_o;
    end

    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_NOP || cmd_o == CMD_PRE || cmd_o == CMD_LMR || cmd_o == CMD_READ); // R1
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_PRE |-> addr_o[AP_BIT]); // R2
    AST_PRE_FROM_REST: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_PRE |-> (last_cmd_q == CMD_NOP || last_cmd_q == CMD_READ)); // R8
    AST_ARM_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_LMR |-> (ba_o == BANK_W'(ARM_BANK) && addr_o == '0)); // R3
    AST_ARM_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_LMR |-> last_cmd_q == CMD_PRE); // R3
    AST_READ_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_READ |-> last_cmd_q == CMD_LMR); // R4
    AST_STATUS_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o) |-> last_cmd_q == CMD_READ); // R5
    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (last_cmd_q == CMD_READ && cmd_o == CMD_NOP)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

endmodule

bind srr_sequencer srr_sequencer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_o    (cmd_o),
    .ba_o     (ba_o),
    .addr_o   (addr_o),
    .status_o (status_o),
    .done_o   (done_o)
);

// File: tb/sim_srr_sequencer.sv
module sim_srr_sequencer;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 13;
    localparam int BANK_W = 2;
    localparam int TMR_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [TMR_W-1:0]  t_rp = '0, t_srr = '0, t_src = '0;
    logic [1:0]        cas_lat = 2'd2;
    logic [3:0]        cmd;
    logic [BANK_W-1:0] ba;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] dq = '0;
    logic              dq_valid = 1'b0;
    logic [DATA_W-1:0] status;
    logic              done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // Device model state
    int               read_cyc = -100;
    int               model_cl = 2;
    bit               model_valid = 1'b1;
    logic [DATA_W-1:0] beat1 = '0, beat2 = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    srr_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .TMR_W(TMR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .t_rp_i(t_rp), .t_srr_i(t_srr), .t_src_i(t_src), .cas_lat_i(cas_lat),
        .cmd_o(cmd), .ba_o(ba), .addr_o(addr),
        .dq_i(dq), .dq_valid_i(dq_valid), .status_o(status), .done_o(done)
    );

    // Device side: two beats at READ+CL and READ+CL+1, noise otherwise
    always @(negedge clk) begin
        if (cmd == 4'b0101) read_cyc = cyc;
        if (model_valid && cyc == read_cyc + model_cl) begin
            dq_valid = 1'b1; dq = beat1;
        end else if (model_valid && cyc == read_cyc + model_cl + 1) begin
            dq_valid = 1'b1; dq = beat2;
        end else begin
            dq_valid = 1'b0; dq = DATA_W'($urandom);
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // One full status read with the given timing; checks R2..R9
    task automatic run_seq(input int trp, input int tsrr, input int tsrc, input int cl,
                           input bit give_valid);
        int q, pre_c, lmr_c, rd_c, done_c, extra, cl_eff;
        logic [DATA_W-1:0] prev;
        cl_eff = (cl == 3) ? 3 : 2;
        pre_c = -1; lmr_c = -1; rd_c = -1; done_c = -1; extra = 0;
        prev = status;
        beat1 = DATA_W'($urandom);
        beat2 = ~beat1;
        model_cl = cl_eff;
        model_valid = give_valid;
        @(negedge clk);
        t_rp = TMR_W'(trp); t_srr = TMR_W'(tsrr); t_src = TMR_W'(tsrc);
        cas_lat = 2'(cl); req = 1'b1;
        q = cyc;
        for (int i = 0; i < 200 && done_c < 0; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req = 1'b0;
                // R9: scramble timing inputs after accept
                t_rp = TMR_W'($urandom_range(0, 40));
                t_srr = TMR_W'($urandom_range(0, 40));
                t_src = TMR_W'($urandom_range(0, 40));
                cas_lat = 2'($urandom);
            end else if (i == 2) begin
                req = 1'b1; // R8: request while busy
            end else if (i == 3) begin
                req = 1'b0;
            end
            if (cmd == 4'b0010 && pre_c < 0) begin
                pre_c = cyc;
                check(addr[10] == 1'b1, "R2 all-bank bit", int'(addr[10]), 1);
            end else if (cmd == 4'b0000 && lmr_c < 0) begin
                lmr_c = cyc;
                check(ba == 2'b01, "R3 arm bank", int'(ba), 1);
                check(addr == '0, "R3 arm address", int'(addr), 0);
            end else if (cmd == 4'b0101 && rd_c < 0) begin
                rd_c = cyc;
            end else if (cmd != 4'b0111) begin
                extra++;
            end
            if (done) done_c = cyc;
        end
        check(pre_c == q + 1, "R2 precharge cycle", pre_c - q, 1);
        check(lmr_c - pre_c == max2(trp, 1), "R3 tRP gap", lmr_c - pre_c, max2(trp, 1));
        check(rd_c - lmr_c == max2(tsrr, 1), "R4 tSRR gap", rd_c - lmr_c, max2(tsrr, 1));
        check(done_c - rd_c == max2(tsrc, cl_eff + 1), "R7 done delay",
              done_c - rd_c, max2(tsrc, cl_eff + 1));
        check(extra == 0, "R7 only NOP in waits", extra, 0);
        if (give_valid)
            check(status == beat1, "R5 R6 status is first beat", int'(status), int'(beat1));
        else
            check(status == prev, "R5 no strobe keeps status", int'(status), int'(prev));
        extra = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 0) check(done == 1'b0, "R7 done one cycle", int'(done), 0);
            if (cmd != 4'b0111) extra++;
        end
        check(extra == 0, "R8 busy request ignored", extra, 0);
        check(give_valid ? status == beat1 : status == prev, "R6 late beat ignored",
              int'(status), give_valid ? int'(beat1) : int'(prev));
    endtask

    // Watchdog
    initial begin
        #1500000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cmd == 4'b0111, "R1 reset command", int'(cmd), 7);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(status == '0, "R1 reset status", int'(status), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd == 4'b0111, "R1 idle command", int'(cmd), 7);
        check(status == '0, "R1 idle status", int'(status), 0);
        for (int cl = 2; cl <= 3; cl++)
            for (int trp = 0; trp <= 4; trp++)
                for (int tsrr = 0; tsrr <= 3; tsrr++)
                    for (int tsrc = 0; tsrc <= 6; tsrc++)
                        run_seq(trp, tsrr, tsrc, cl, 1'b1);
        run_seq(2, 2, 3, 0, 1'b1);   // R5: setting 0 behaves as latency 2
        run_seq(1, 3, 2, 1, 1'b1);   // R5: setting 1 behaves as latency 2
        run_seq(3, 1, 5, 3, 1'b0);   // R5: no strobe, status kept
        run_seq(2, 2, 9, 2, 1'b0);
        run_seq(12, 9, 14, 3, 1'b1); // longer waits
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule